// File: doc/BRIEF.md
# Gyro SPI Command Frame Engine

This block talks to an SPI angular-rate sensor on behalf of a host. The host asks for one of four operations: a rate sample, a register read, a register write, or a raw 32-bit exchange. The block builds the 32-bit command word and adds the odd-parity bit. It shifts the word out in SPI mode 0 and collects whatever the sensor returns.

The sensor answers a command in the frame that follows it. For rate and register reads, the engine therefore raises chip-select for a short gap and then clocks a second, all-zero frame. From that second frame it takes the answer. The bit field it extracts depends on the command type. A register write needs only one frame. It is followed by a quiet interval, and no new traffic may begin until that interval ends.

The raw exchange sends a host-supplied word unchanged and returns the word clocked in during the same frame. A startup sequencer uses it. The host sees a start pulse, a busy level, and a result that stays valid until the host acknowledges it.

Top module: `gyro_frame_engine`

## Requirements
- R1: Each frame is 32 SCLK periods with chip-select low, most significant bit first. SCLK idles low, MOSI is stable before each rising edge, and MISO is sampled on the rising edge. One SCLK period lasts 2*CLK_DIV system clocks.
- R2: req_op encodes 0 = rate sample, 1 = register read, 2 = register write, 3 = raw. Command bits 31:24 are 0x20 for a rate sample, 0x80 for a read and 0x40 for a write.
- R3: For reads and writes, the register address is ORed into command bits 24:17. For writes, the data goes into bits 16:1. All other command bits are zero apart from parity.
- R4: Command bit 0 is set exactly when needed to make the number of ones in the 32-bit command odd.
- R5: A rate sample or register read uses two chip-select periods. The second frame sends all zeros and begins after chip-select has been high for at least CS_GAP system clocks.
- R6: A register read returns bits 20:5 of the second received frame on rsp_data. A rate sample returns bits 25:10 of that frame as a two's-complement value.
- R7: A register write uses one frame, and rsp_valid rises no sooner than WR_QUIET clocks after chip-select goes high. The next chip-select fall therefore comes at least WR_QUIET clocks after the write frame. rsp_data is zero.
- R8: A raw exchange sends req_raw unchanged in a single frame. It returns the 32 bits received during that frame on rsp_raw, with rsp_data zero.
- R9: busy is high from the clock after an accepted req_start until the result is acknowledged. A req_start while busy is high starts no frame and does not change the operation in progress.
- R10: Once rsp_valid is high, it stays high with rsp_data and rsp_raw unchanged until a cycle with rsp_ready high.
- R11: After reset, cs_n is 1, sclk is 0, busy is 0 and rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 2 | Operation code |
| req_addr | input | 8 | Register address |
| req_wdata | input | 16 | Register write data |
| req_raw | input | 32 | Frame to send in raw mode |
| busy | output | 1 | Operation in progress |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Host accepts the result |
| rsp_data | output | 16 | Extracted data field |
| rsp_raw | output | 32 | Last frame received |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | SPI chip-select, active low |
| mosi | output | 1 | Serial data to sensor |
| miso | input | 1 | Serial data from sensor |

## Verification
Two situations are hardest to reach from the ports. The first is a fresh request that arrives while a two-frame read is still between its frames or inside one. The second is a request that would break the quiet window after a write. The stimulus handles the first case by pulsing req_start with a write code in the middle of a read's command frame. It then counts chip-select periods at the sensor model and idles long enough to show that no stray frame follows. For the write window, the bench measures in clocks the time from chip-select rising to rsp_valid. The sensor model loads a distinct reply for every frame, so a response taken from the wrong frame or the wrong bit field produces a visibly wrong value.

// File: rtl/gyro_frame_pkg.sv
package gyro_frame_pkg;

    localparam int FRAME_W = 32;

    typedef enum logic [1:0] {
        OP_SENSOR = 2'd0,
        OP_REG_RD = 2'd1,
        OP_REG_WR = 2'd2,
        OP_RAW    = 2'd3
    } gyro_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_GAP,
        S_RSP,
        S_QUIET,
        S_DONE
    } gyro_state_e;

    localparam logic [7:0] TAG_SENSOR = 8'h20;
    localparam logic [7:0] TAG_WRITE  = 8'h40;
    localparam logic [7:0] TAG_READ   = 8'h80;

    // Command word with odd parity in bit 0; raw words pass untouched.
    function automatic logic [FRAME_W-1:0] make_cmd(
        input gyro_op_e         op,
        input logic [7:0]       addr,
        input logic [15:0]      wdata,
        input logic [FRAME_W-1:0] raw
    );
        logic [FRAME_W-1:0] f;
        f = '0;
        case (op)
            OP_SENSOR: f = {TAG_SENSOR, 24'h0};
            OP_REG_RD: f = {TAG_READ, 24'h0} | ({24'h0, addr} << 17);
            OP_REG_WR: f = {TAG_WRITE, 24'h0} | ({24'h0, addr} << 17)
                           | ({16'h0, wdata} << 1);
            default:   f = raw;
        endcase
        if (op != OP_RAW)
            f[0] = ~(^f[FRAME_W-1:1]);
        return f;
    endfunction

    // Field position in the reply frame depends on the command type.
    function automatic logic [15:0] pick_field(
        input gyro_op_e           op,
        input logic [FRAME_W-1:0] rx
    );
        case (op)
            OP_SENSOR: return rx[25:10];
            OP_REG_RD: return rx[20:5];
            default:   return 16'h0;
        endcase
    endfunction

endpackage

// File: rtl/gyro_spi_shifter.sv
module gyro_spi_shifter
    import gyro_frame_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx,
    output logic               done,
    output logic [FRAME_W-1:0] rx,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi,
    input  logic               miso
);
    localparam int DIV_W = $clog2(CLK_DIV + 1);
    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

    logic               active;
    logic [DIV_W-1:0]   div_cnt;
    logic [BIT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] tx_sr;
    logic [FRAME_W-1:0] rx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            cs_n    <= 1'b1;
            sclk    <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active  <= 1'b1;
                    cs_n    <= 1'b0;
                    sclk    <= 1'b0;
                    tx_sr   <= tx;
                    div_cnt <= '0;
                    bit_cnt <= '0;
                end
            end else if (div_cnt == DIV_LAST) begin
                div_cnt <= '0;
                if (!sclk) begin
                    sclk  <= 1'b1;
                    rx_sr <= {rx_sr[FRAME_W-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_cnt == BIT_LAST) begin
                        active <= 1'b0;
                        cs_n   <= 1'b1;
                        done   <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        tx_sr   <= {tx_sr[FRAME_W-2:0], 1'b0};
                    end
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    assign mosi = tx_sr[FRAME_W-1];
    assign rx   = rx_sr;

    // R1: clock edges only inside a chip-select period
    a_r1_sclk_framed: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> !cs_n);
    // R1: clock parked low whenever the sensor is deselected
    a_r1_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);
    // R5: a finished frame always leaves chip-select high for a cycle
    a_r5_cs_released: assert property (@(posedge clk) disable iff (rst)
        done |=> cs_n);

endmodule

// File: rtl/gyro_gap_timer.sv
module gyro_gap_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/gyro_frame_engine.sv
module gyro_frame_engine
    import gyro_frame_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int CS_GAP   = 8,
    parameter int WR_QUIET = 20000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_start,
    input  logic [1:0]  req_op,
    input  logic [7:0]  req_addr,
    input  logic [15:0] req_wdata,
    input  logic [31:0] req_raw,
    output logic        busy,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [15:0] rsp_data,
    output logic [31:0] rsp_raw,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso
);
    localparam int TMR_MAX = (WR_QUIET > CS_GAP) ? WR_QUIET : CS_GAP;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    gyro_state_e        state;
    gyro_op_e           op_q;
    logic               sh_start;
    logic [FRAME_W-1:0] sh_tx;
    logic               sh_done;
    logic [FRAME_W-1:0] sh_rx;
    logic               tmr_load;
    logic [TMR_W-1:0]   tmr_val;
    logic               tmr_expired;

    gyro_spi_shifter #(.CLK_DIV(CLK_DIV)) shifter_i (
        .clk   (clk),
        .rst   (rst),
        .start (sh_start),
        .tx    (sh_tx),
        .done  (sh_done),
        .rx    (sh_rx),
        .sclk  (sclk),
        .cs_n  (cs_n),
        .mosi  (mosi),
        .miso  (miso)
    );

    // Timer starts as the command frame ends: either the inter-frame gap or the write quiet time.
    assign tmr_load = (state == S_CMD) && sh_done && (op_q != OP_RAW);
    assign tmr_val  = (op_q == OP_REG_WR) ? TMR_W'(WR_QUIET) : TMR_W'(CS_GAP);

    gyro_gap_timer #(.W(TMR_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            op_q     <= OP_SENSOR;
            sh_start <= 1'b0;
            sh_tx    <= '0;
            rsp_data <= '0;
            rsp_raw  <= '0;
        end else begin
            sh_start <= 1'b0;
            case (state)
                S_IDLE: if (req_start) begin
                    op_q     <= gyro_op_e'(req_op);
                    sh_tx    <= make_cmd(gyro_op_e'(req_op), req_addr, req_wdata, req_raw);
                    sh_start <= 1'b1;
                    state    <= S_CMD;
                end
                S_CMD: if (sh_done) begin
                    rsp_raw <= sh_rx;
                    case (op_q)
                        OP_RAW:    begin rsp_data <= '0; state <= S_DONE;  end
                        OP_REG_WR: begin rsp_data <= '0; state <= S_QUIET; end
                        default:   state <= S_GAP;
                    endcase
                end
                S_GAP: if (tmr_expired) begin
                    sh_tx    <= '0;
                    sh_start <= 1'b1;
                    state    <= S_RSP;
                end
                S_RSP: if (sh_done) begin
                    rsp_raw  <= sh_rx;
                    rsp_data <= pick_field(op_q, sh_rx);
                    state    <= S_DONE;
                end
                S_QUIET: if (tmr_expired) state <= S_DONE;
                S_DONE:  if (rsp_ready) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy      = (state != S_IDLE);
    assign rsp_valid = (state == S_DONE);

    // Independent window counter for the post-write quiet check.
    logic [TMR_W-1:0] since_wr;
    logic             wr_armed;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_wr <= '0;
            wr_armed <= 1'b0;
        end else if (sh_done && state == S_CMD && op_q == OP_REG_WR) begin
            since_wr <= '0;
            wr_armed <= 1'b1;
        end else if (since_wr < TMR_W'(WR_QUIET)) begin
            since_wr <= since_wr + 1'b1;
        end
    end

    // R7: no chip-select fall inside the quiet window after a write
    a_r7_write_quiet: assert property (@(posedge clk) disable iff (rst)
        ($fell(cs_n) && wr_armed) |-> (since_wr >= TMR_W'(WR_QUIET)));
    // R4: every built command carries odd parity
    a_r4_odd_parity: assert property (@(posedge clk) disable iff (rst)
        (sh_start && state == S_CMD && op_q != OP_RAW) |-> ($countones(sh_tx) % 2 == 1));
    // R9: a strobe while busy leaves the current operation untouched
    a_r9_ignore_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && req_start) |=> $stable(op_q));
    // R10: result held until acknowledged
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_raw)));
    // R9: a result is never offered while idle
    a_r9_valid_busy: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> busy);

endmodule

// File: tb/gyro_frame_engine_tb_top.sv
`timescale 1ns/1ps
module gyro_frame_engine_tb_top;
    localparam int CLK_DIV  = 2;
    localparam int CS_GAP   = 4;
    localparam int WR_QUIET = 50;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_start = 1'b0;
    logic [1:0]  req_op = '0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [31:0] req_raw = '0;
    logic        busy, rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [15:0] rsp_data;
    logic [31:0] rsp_raw;
    logic        sclk, cs_n, mosi, miso;

    always #2.5 clk = ~clk;

    gyro_frame_engine #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .WR_QUIET(WR_QUIET)) dut_i (
        .clk(clk), .rst(rst), .req_start(req_start), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_raw(req_raw),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_raw(rsp_raw),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    // ---------------- sensor model ----------------
    logic [31:0] reply [0:63];
    logic [31:0] cap   [0:63];
    int          nbits [0:63];
    int          fidx = 0;
    int          bitn = 0;
    logic [31:0] shin = '0;

    assign miso = (bitn < 32) ? reply[fidx % 64][5'(31 - bitn)] : 1'b0;

    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            if (bitn != 0) begin
                cap[fidx % 64]   = shin;
                nbits[fidx % 64] = bitn;
                fidx             = fidx + 1;
            end
            bitn = 0;
        end else begin
            shin = {shin[30:0], mosi};
            bitn = bitn + 1;
        end
    end

    int hi_cnt = 0, last_gap = 0;
    int per_cnt = 0, sclk_per = 0;
    logic sclk_d = 1'b0;
    always @(posedge clk) begin
        if (cs_n) hi_cnt <= hi_cnt + 1;
        else begin
            if (hi_cnt != 0) last_gap <= hi_cnt;
            hi_cnt <= 0;
        end
        sclk_d <= sclk;
        if (sclk && !sclk_d) begin
            sclk_per <= per_cnt;
            per_cnt  <= 1;
        end else per_cnt <= per_cnt + 1;
    end

    // ---------------- checking ----------------
    int total = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_cmd(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
        logic [31:0] f;
        case (op)
            2'd0: f = 32'h2000_0000;
            2'd1: f = 32'h8000_0000 | ({24'h0, a} << 17);
            default: f = 32'h4000_0000 | ({24'h0, a} << 17) | ({16'h0, d} << 1);
        endcase
        if ((^f) == 1'b0) f[0] = 1'b1;
        return f;
    endfunction

    logic [15:0] got_data;
    logic [31:0] got_raw;
    int          base;

    task automatic issue(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d, input logic [31:0] raw);
        @(negedge clk);
        req_op = op; req_addr = a; req_wdata = d; req_raw = raw;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
    endtask

    task automatic finish_op();
        while (!rsp_valid) @(negedge clk);
        got_data = rsp_data;
        got_raw  = rsp_raw;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk(cs_n === 1'b1, "R11 cs_n after reset", 32'(cs_n), 32'h1);
        chk(sclk === 1'b0, "R11 sclk after reset", 32'(sclk), 32'h0);
        chk(busy === 1'b0, "R11 busy after reset", 32'(busy), 32'h0);
        chk(rsp_valid === 1'b0, "R11 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    endtask

    task automatic t_sensor();
        base = fidx;
        reply[base % 64]       = 32'hFFFF_FFFF;
        reply[(base + 1) % 64] = 32'h0AE5_5C00;
        issue(2'd0, 8'h00, 16'h0, 32'h0);
        chk(busy === 1'b1, "R9 busy after accept", 32'(busy), 32'h1);
        finish_op();
        chk(fidx - base == 2, "R5 sensor frame count", 32'(fidx - base), 32'd2);
        chk(cap[base % 64] == exp_cmd(2'd0, 8'h0, 16'h0), "R2 sensor command", cap[base % 64], exp_cmd(2'd0, 8'h0, 16'h0));
        chk(cap[(base + 1) % 64] == 32'h0, "R5 second frame zero", cap[(base + 1) % 64], 32'h0);
        chk(nbits[base % 64] == 32, "R1 bits per frame", 32'(nbits[base % 64]), 32'd32);
        chk(sclk_per == 2 * CLK_DIV, "R1 sclk period", 32'(sclk_per), 32'(2 * CLK_DIV));
        chk(last_gap >= CS_GAP, "R5 chip-select gap", 32'(last_gap), 32'(CS_GAP));
        chk(got_data == reply[(base + 1) % 64][25:10], "R6 sensor field", 32'(got_data), 32'(reply[(base + 1) % 64][25:10]));
        chk(got_raw == reply[(base + 1) % 64], "R6 sensor raw reply", got_raw, reply[(base + 1) % 64]);
    endtask

    task automatic t_read(input logic [7:0] a, input logic [31:0] r2);
        logic [31:0] e;
        base = fidx;
        reply[base % 64]       = 32'h1234_5678;
        reply[(base + 1) % 64] = r2;
        issue(2'd1, a, 16'h0, 32'h0);
        finish_op();
        e = exp_cmd(2'd1, a, 16'h0);
        chk(cap[base % 64] == e, "R3 read command", cap[base % 64], e);
        chk((^cap[base % 64]) == 1'b1, "R4 read parity odd", cap[base % 64], e);
        chk(got_data == r2[20:5], "R6 read field", 32'(got_data), 32'(r2[20:5]));
    endtask

    task automatic t_write(input logic [7:0] a, input logic [15:0] d);
        logic [31:0] e;
        int wait_cyc;
        base = fidx;
        reply[base % 64] = 32'hA5A5_A5A5;
        issue(2'd2, a, d, 32'h0);
        @(posedge cs_n);
        wait_cyc = 0;
        @(negedge clk);
        while (!rsp_valid) begin wait_cyc++; @(negedge clk); end
        finish_op();
        e = exp_cmd(2'd2, a, d);
        chk(cap[base % 64] == e, "R3 write command", cap[base % 64], e);
        chk((^cap[base % 64]) == 1'b1, "R4 write parity odd", cap[base % 64], e);
        chk(fidx - base == 1, "R7 write single frame", 32'(fidx - base), 32'd1);
        chk(wait_cyc >= WR_QUIET, "R7 quiet window", 32'(wait_cyc), 32'(WR_QUIET));
        chk(got_data == 16'h0, "R7 write data zero", 32'(got_data), 32'h0);
    endtask

    task automatic t_raw();
        base = fidx;
        reply[base % 64] = 32'h0000_0001;
        issue(2'd3, 8'hFF, 16'hFFFF, 32'h2000_0003);
        finish_op();
        chk(cap[base % 64] == 32'h2000_0003, "R8 raw sent verbatim", cap[base % 64], 32'h2000_0003);
        chk(got_raw == 32'h0000_0001, "R8 raw received", got_raw, 32'h0000_0001);
        chk(fidx - base == 1, "R8 raw single frame", 32'(fidx - base), 32'd1);
        chk(got_data == 16'h0, "R8 raw data zero", 32'(got_data), 32'h0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] r2;
        r2 = 32'h0013_57E0;
        base = fidx;
        reply[base % 64]       = 32'h0;
        reply[(base + 1) % 64] = r2;
        issue(2'd1, 8'h0A, 16'h0, 32'h0);
        repeat (20) @(negedge clk);
        req_op = 2'd2; req_addr = 8'h12; req_wdata = 16'h03FF;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        finish_op();
        repeat (200) @(negedge clk);
        chk(fidx - base == 2, "R9 ignored start frames", 32'(fidx - base), 32'd2);
        chk(cap[base % 64] == exp_cmd(2'd1, 8'h0A, 16'h0), "R9 read kept", cap[base % 64], exp_cmd(2'd1, 8'h0A, 16'h0));
        chk(got_data == r2[20:5], "R9 read result intact", 32'(got_data), 32'(r2[20:5]));
        chk(busy === 1'b0, "R9 idle after ack", 32'(busy), 32'h0);
    endtask

    task automatic t_hold();
        logic [15:0] d0;
        base = fidx;
        reply[base % 64]       = 32'h0;
        reply[(base + 1) % 64] = 32'h03FF_FC00;
        issue(2'd0, 8'h0, 16'h0, 32'h0);
        while (!rsp_valid) @(negedge clk);
        d0 = rsp_data;
        repeat (15) @(negedge clk);
        chk(rsp_valid === 1'b1, "R10 valid held", 32'(rsp_valid), 32'h1);
        chk(rsp_data == d0, "R10 data held", 32'(rsp_data), 32'(d0));
        chk(d0 == 16'hFFFF, "R6 negative rate field", 32'(d0), 32'hFFFF);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(rsp_valid === 1'b0, "R10 released by ready", 32'(rsp_valid), 32'h0);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin reply[i] = '0; cap[i] = '0; nbits[i] = 0; end
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sensor();
        t_read(8'h08, 32'h8E12_3460);
        t_read(8'h7E, 32'h001F_FFE0);
        t_write(8'h12, 16'h03FF);
        t_write(8'h00, 16'h0000);
        t_raw();
        t_busy_ignore();
        t_hold();
        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule